// File: doc/BRIEF.md
# Masked Mixed-Sign Byte Dot-Product Accumulator

This block is a SIMD integer datapath that splits a wide vector into 32-bit lanes. Each lane holds four byte pairs. The byte from the first source is read as unsigned and the byte from the second source is read as signed. Their four products are added to the lane's incoming 32-bit accumulator value. It is the inner step of quantised matrix arithmetic, where unsigned activations are multiplied by signed weights.

Each operation is presented as a single-cycle `in_valid` pulse. The operation carries the following controls:

- a vector-length code, which picks 4, 8 or 16 active lanes;
- an accumulator vector;
- the two source vectors;
- a 16-bit per-lane write mask, with an enable and a zeroing/merging select;
- a broadcast flag, which feeds the second source's lowest dword to every lane.

The full-width result is registered. It appears one cycle later together with a one-cycle `out_valid`.

Top module: `bytedot_acc`

## Requirements
- R1: Each byte of `src_u` is zero-extended to 16 bits and each byte of `src_s` is sign-extended to 16 bits before they are multiplied, so 0xFF × 0x80 gives −32640.
- R2: An active, written lane i becomes `acc_in` lane i plus the four products of bytes 4i..4i+3, summed modulo 2^32 with no saturation (0x7FFFFFFF + 1 gives 0x80000000).
- R3: `vlen_sel` gives the active lane count: 2'b00 gives 4 lanes (128 bits), 2'b01 gives 8 lanes (256 bits), and 2'b10 or 2'b11 gives 16 lanes (512 bits).
- R4: Every result bit above the selected vector length is zero.
- R5: With `mask_en`=1, `zero_mode`=1 and `lane_mask[i]`=0, active lane i is zero.
- R6: With `mask_en`=1, `zero_mode`=0 and `lane_mask[i]`=0, active lane i equals `acc_in` lane i.
- R7: With `mask_en`=0, every active lane is updated whatever `lane_mask` holds.
- R8: With `bcast`=1, every lane takes its four signed bytes from bits [31:0] of `src_s`.
- R9: `out_valid` is high for exactly the cycle after each cycle in which `in_valid` is high. Both outputs are zero after reset.
- R10: Mask bits for lanes at or above the active lane count have no effect on the result.
- R11: `result` holds its value in cycles that follow a cycle with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| vlen_sel | input | 2 | Vector length code |
| acc_in | input | 512 | Accumulator vector, 16 × 32-bit lanes |
| src_u | input | 512 | Unsigned byte source |
| src_s | input | 512 | Signed byte source |
| lane_mask | input | 16 | Per-lane write mask |
| mask_en | input | 1 | Apply lane_mask |
| zero_mode | input | 1 | 1: zero masked lanes, 0: keep accumulator |
| bcast | input | 1 | Use src_s dword 0 for every lane |
| out_valid | output | 1 | Result strobe |
| result | output | 512 | Updated destination vector |

## Verification
The only state is the result register and the valid flag, so a wrong lane computation shows up in the result on the cycle after the operation is presented. A wrong extension choice (zero versus sign) shows only when a byte has its top bit set. The all-0xFF by all-0x80 pattern therefore shows it in every lane at once. A fault in lane selection shows only for particular length, mask and broadcast combinations, so every combination of these controls is driven. A latch-through fault in the hold path shows in the first idle cycle, as a result that changed while no operation was present.

// File: rtl/bytedot_pkg.sv
package bytedot_pkg;
  localparam int BYTE_W    = 8;
  localparam int LANE_W    = 32;
  localparam int MAX_LANES = 16;
  localparam int MIN_LANES = 4;
  localparam int VEC_W     = MAX_LANES * LANE_W;

  typedef enum logic [1:0] {
    VL_SHORT = 2'b00,
    VL_MID   = 2'b01,
    VL_LONG  = 2'b10,
    VL_LONG2 = 2'b11
  } vlen_e;

  function automatic int active_lanes(input logic [1:0] code);
    case (code)
      VL_SHORT: return MIN_LANES;
      VL_MID:   return MIN_LANES * 2;
      default:  return MIN_LANES * 4;
    endcase
  endfunction
endpackage

// File: rtl/bytedot_lane_ctl.sv
module bytedot_lane_ctl
  import bytedot_pkg::*;
#(
  parameter int LANES = MAX_LANES
) (
  input  logic [1:0]       vlen_sel,
  input  logic [LANES-1:0] lane_mask,
  input  logic             mask_en,
  output logic [LANES-1:0] lane_active,
  output logic [LANES-1:0] lane_write
);
  int n_active;

  always_comb n_active = active_lanes(vlen_sel);

  for (genvar i = 0; i < LANES; i++) begin : g_ctl
    assign lane_active[i] = (i < n_active);
    assign lane_write[i]  = lane_active[i] && (!mask_en || lane_mask[i]);
  end
endmodule

// File: rtl/bytedot_lane.sv
module bytedot_lane #(
  parameter int BYTE_W = 8,
  parameter int LANE_W = 32
) (
  input  logic [LANE_W-1:0] acc,
  input  logic [LANE_W-1:0] u_word,
  input  logic [LANE_W-1:0] s_word,
  input  logic              active,
  input  logic              upd,
  input  logic              zero_mode,
  output logic [LANE_W-1:0] res
);
  localparam int NB = LANE_W / BYTE_W;
  localparam int PW = 2 * BYTE_W;

  logic signed [PW-1:0] prod [NB];
  logic [LANE_W-1:0]    sum;

  for (genvar b = 0; b < NB; b++) begin : g_prod
    logic signed [PW-1:0] u_ext, s_ext;
    assign u_ext   = $signed({{BYTE_W{1'b0}}, u_word[b*BYTE_W +: BYTE_W]});
    assign s_ext   = $signed({{BYTE_W{s_word[b*BYTE_W+BYTE_W-1]}},
                              s_word[b*BYTE_W +: BYTE_W]});
    assign prod[b] = u_ext * s_ext;
  end

  always_comb begin
    sum = acc;
    for (int k = 0; k < NB; k++) begin
      sum = sum + LANE_W'(prod[k]);
    end
  end

  always_comb begin
    if (!active)        res = '0;
    else if (upd)       res = sum;
    else if (zero_mode) res = '0;
    else                res = acc;
  end
endmodule

// File: rtl/bytedot_acc.sv
module bytedot_acc
  import bytedot_pkg::*;
#(
  parameter int LANES = MAX_LANES,
  parameter int LW    = LANE_W,
  parameter int BW    = BYTE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [1:0]          vlen_sel,
  input  logic [LANES*LW-1:0] acc_in,
  input  logic [LANES*LW-1:0] src_u,
  input  logic [LANES*LW-1:0] src_s,
  input  logic [LANES-1:0]    lane_mask,
  input  logic                mask_en,
  input  logic                zero_mode,
  input  logic                bcast,
  output logic                out_valid,
  output logic [LANES*LW-1:0] result
);
  localparam int VW = LANES * LW;

  logic [LANES-1:0] lane_active, lane_write;
  logic [VW-1:0]    next_res;

  bytedot_lane_ctl #(.LANES(LANES)) u_ctl (
    .vlen_sel    (vlen_sel),
    .lane_mask   (lane_mask),
    .mask_en     (mask_en),
    .lane_active (lane_active),
    .lane_write  (lane_write)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LW-1:0] s_pick;
    assign s_pick = bcast ? src_s[LW-1:0] : src_s[i*LW +: LW];

    bytedot_lane #(.BYTE_W(BW), .LANE_W(LW)) u_lane (
      .acc       (acc_in[i*LW +: LW]),
      .u_word    (src_u[i*LW +: LW]),
      .s_word    (s_pick),
      .active    (lane_active[i]),
      .upd       (lane_write[i]),
      .zero_mode (zero_mode),
      .res       (next_res[i*LW +: LW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end
endmodule

// File: rtl/bytedot_acc_chk.sv
module bytedot_acc_chk #(
  parameter int LANES = 16,
  parameter int LW    = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [1:0]          vlen_sel,
  input logic [LANES*LW-1:0] acc_in,
  input logic [LANES-1:0]    lane_mask,
  input logic                mask_en,
  input logic                zero_mode,
  input logic                out_valid,
  input logic [LANES*LW-1:0] result
);
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_single_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  assert_upper_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vlen_sel == 2'b00) |=> (result[LANES*LW-1:4*LW] == '0));

  assert_zeroing_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en && zero_mode && !lane_mask[0]) |=> (result[LW-1:0] == '0));

  assert_merging_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en && !zero_mode && !lane_mask[0])
      |=> (result[LW-1:0] == $past(acc_in[LW-1:0])));
endmodule

bind bytedot_acc bytedot_acc_chk #(.LANES(LANES), .LW(LW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .vlen_sel  (vlen_sel),
  .acc_in    (acc_in),
  .lane_mask (lane_mask),
  .mask_en   (mask_en),
  .zero_mode (zero_mode),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/tb_bytedot_acc.sv
module tb_bytedot_acc;
  localparam int L  = 16;
  localparam int VW = 512;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [1:0]    vlen_sel = 2'b00;
  logic [VW-1:0] acc_in = '0, src_u = '0, src_s = '0;
  logic [L-1:0]  lane_mask = '0;
  logic          mask_en = 1'b0, zero_mode = 1'b0, bcast = 1'b0;
  logic          out_valid;
  logic [VW-1:0] result;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R9 R11";
  logic          m_valid;
  logic [VW-1:0] m_res;

  always #5 clk = ~clk;

  bytedot_acc dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .vlen_sel(vlen_sel),
    .acc_in(acc_in), .src_u(src_u), .src_s(src_s), .lane_mask(lane_mask),
    .mask_en(mask_en), .zero_mode(zero_mode), .bcast(bcast),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [VW-1:0] model(
      input logic [1:0] vl, input logic [VW-1:0] a, input logic [VW-1:0] u,
      input logic [VW-1:0] s, input logic [L-1:0] m, input logic me,
      input logic zm, input logic bc);
    logic [VW-1:0] r = '0;
    int n = (vl == 2'b00) ? 4 : (vl == 2'b01) ? 8 : 16;
    for (int i = 0; i < n; i++) begin
      logic [31:0] t = bc ? s[31:0] : s[i*32 +: 32];
      logic [31:0] acc = a[i*32 +: 32];
      if (!me || m[i]) begin
        for (int b = 0; b < 4; b++) begin
          int uv = int'(u[i*32 + b*8 +: 8]);
          int sv = int'($signed(t[b*8 +: 8]));
          acc = acc + 32'(uv * sv);
        end
        r[i*32 +: 32] = acc;
      end else if (!zm) begin
        r[i*32 +: 32] = acc;
      end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_res   <= '0;
    end else begin
      m_valid <= in_valid;
      if (in_valid)
        m_res <= model(vlen_sel, acc_in, src_u, src_s, lane_mask, mask_en, zero_mode, bcast);
    end
  end

  task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(cur_req, VW'(out_valid), VW'(m_valid));
      check(cur_req, result, m_res);
    end
  end

  task automatic op(input logic [1:0] vl, input logic [VW-1:0] a, input logic [VW-1:0] u,
                    input logic [VW-1:0] s, input logic [L-1:0] m, input logic me,
                    input logic zm, input logic bc);
    vlen_sel = vl; acc_in = a; src_u = u; src_s = s;
    lane_mask = m; mask_en = me; zero_mode = zm; bcast = bc;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int k = 0; k < VW/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs are zero while in reset
    check("R9", {result, 1'b0}, '0);
    check("R9", VW'(out_valid), '0);
    rst = 1'b0;
    @(negedge clk);

    // R1: 0xFF x 0x80 in every byte, 16 lanes, each lane expects 0xFFFE0200
    cur_req = "R1";
    op(2'b10, '0, {VW{1'b1}}, {(VW/8){8'h80}}, '0, 1'b0, 1'b0, 1'b0);
    check("R1", VW'(result[31:0]), VW'(32'hFFFE0200));
    check("R1", VW'(result[511:480]), VW'(32'hFFFE0200));

    // R2: accumulator wraps from 0x7FFFFFFF
    cur_req = "R2";
    op(2'b00, {{(VW-32){1'b0}}, 32'h7FFFFFFF}, VW'(32'h01), VW'(32'h01), '0, 1'b0, 1'b0, 1'b0);
    check("R2", VW'(result[31:0]), VW'(32'h80000000));

    // R8: broadcast of dword 0 reaches lane 15
    cur_req = "R8";
    op(2'b11, '0, {(VW/8){8'h01}}, VW'(32'h01010101), '0, 1'b0, 1'b0, 1'b1);
    check("R8", VW'(result[511:480]), VW'(32'd4));

    // R5 zeroing, R6 merging, R7 mask disabled
    cur_req = "R5";
    op(2'b10, {(VW/32){32'h12345678}}, {(VW/8){8'h02}}, {(VW/8){8'h03}}, '0, 1'b1, 1'b1, 1'b0);
    check("R5", VW'(result[191:160]), '0);
    cur_req = "R6";
    op(2'b10, {(VW/32){32'h12345678}}, {(VW/8){8'h02}}, {(VW/8){8'h03}}, '0, 1'b1, 1'b0, 1'b0);
    check("R6", VW'(result[191:160]), VW'(32'h12345678));
    cur_req = "R7";
    op(2'b10, {(VW/32){32'h12345678}}, {(VW/8){8'h02}}, {(VW/8){8'h03}}, '0, 1'b0, 1'b1, 1'b0);
    check("R7", VW'(result[191:160]), VW'(32'h12345678 + 32'd24));

    // R10: upper mask bits with short length, upper result stays zero
    cur_req = "R10";
    op(2'b00, rnd_vec(), rnd_vec(), rnd_vec(), 16'hFFF0, 1'b1, 1'b0, 1'b0);
    check("R4", result[VW-1:128] , '0);

    // R11: idle cycles keep the result
    cur_req = "R11";
    repeat (4) @(negedge clk);

    // R3 R4 R5 R6 R7 R8: every length, mask mode and broadcast combination
    cur_req = "R3 R4 R5 R6 R7 R8";
    for (int c = 0; c < 32; c++) begin
      op(2'(c >> 3), rnd_vec(), rnd_vec(), rnd_vec(), 16'($urandom),
         c[2], c[1], c[0]);
      if (c % 4 == 3) @(negedge clk);
    end

    // R1 R2 R10 R11: random traffic with gaps
    cur_req = "R1 R2 R10 R11";
    for (int k = 0; k < 300; k++) begin
      op(2'($urandom), rnd_vec(), rnd_vec(), rnd_vec(), 16'($urandom),
         1'($urandom), 1'($urandom), 1'($urandom));
      if ($urandom % 3 == 0) @(negedge clk);
    end
    repeat (2) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule